// File: doc/BRIEF.md
# VLAN Filter Table with Promiscuous Sequencer

This block keeps a one-bit-per-VLAN accept table covering every 12-bit VLAN identifier and answers, for the VID of a tagged frame, whether that frame is accepted. The table is held as 128 words of 32 bits. A VID selects word VID[11:5] and bit VID[4:0] inside that word. A filter-enable input gates the check. While it is low, every VID is accepted.

Next to the table the block keeps an active-VLAN shadow bitmap of the same shape and one management VID. A built-in sequencer moves the table in and out of VLAN-promiscuous operation. The enable command fills every table word with ones. The disable command rebuilds each word from the shadow bitmap and always keeps the management VID's bit set. Software-side logic can also write single table words directly, and any table word can be read back.

Top module: `vlan_filter_seq`

## Requirements
- R1: With `filt_en` high, `lk_accept` equals bit VID[4:0] of table word VID[11:5] for the VID on `lk_vid`. This holds for VID 0 (word 0 bit 0) and for VID 4095 (word 127 bit 31).
- R2: With `filt_en` low, `lk_accept` is 1 for every VID, whatever the table holds.
- R3: A `promisc_on` command taken while not promiscuous writes 32'hFFFFFFFF to one word per cycle, from word 127 down to word 0. `busy` is high for exactly 128 cycles, starting the cycle after the command is sampled.
- R4: `promisc_on` while already promiscuous changes nothing and does not raise `busy`. `promisc_off` while not promiscuous likewise changes nothing.
- R5: A `promisc_off` command taken while promiscuous rewrites each word with its shadow word, one word per cycle. Blocks of 8 words are handled in ascending order, and the words inside a block go from the highest index down: 7..0, then 15..8, and so on.
- R6: During a rebuild, the word that holds the management VID has that VID's bit forced to 1, whatever the shadow holds.
- R7: A direct write (`tbl_we`) updates the addressed word, and `rd_data` shows table word `rd_idx`. A direct write made while `busy` is high is ignored.
- R8: A command that arrives while `busy` is high is held. It is acted on once the current sequence ends, and the most recent held command wins.
- R9: After reset every table word and shadow word is 0, the management VID is 0, the block is not promiscuous and `busy` is low.
- R10: If `promisc_on` and `promisc_off` are high in the same cycle, the enable command is the one taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | Filter enable; low accepts all VIDs |
| lk_vid | input | 12 | VID under lookup |
| lk_accept | output | 1 | Accept result for `lk_vid` |
| tbl_we | input | 1 | Direct table word write strobe |
| tbl_idx | input | 7 | Direct write word index |
| tbl_data | input | 32 | Direct write word value |
| rd_idx | input | 7 | Table word to read |
| rd_data | output | 32 | Current value of table word `rd_idx` |
| shadow_we | input | 1 | Shadow word write strobe |
| shadow_idx | input | 7 | Shadow word index |
| shadow_data | input | 32 | Shadow word value |
| mgmt_we | input | 1 | Management VID write strobe |
| mgmt_vid | input | 12 | Management VID value |
| promisc_on | input | 1 | Enter VLAN-promiscuous (fill) command |
| promisc_off | input | 1 | Leave VLAN-promiscuous (rebuild) command |
| busy | output | 1 | Sequencer running |

## Verification
The assertions assume that the shadow bitmap and the management VID stay still while a rebuild runs. The rebuild reads them live, so a change in the middle would mix old and new contents, and the management-bit property would compare against a moved target. The bench therefore writes shadow words and the management VID only while `busy` is low. It issues commands as single-cycle pulses, and during a sequence it drives only commands and direct table writes (the latter to show that they are dropped). The random phase mixes direct table writes, shadow writes and lookups. Directed cases cover the table ends, the block order of the rebuild, held commands and simultaneous commands.

// File: rtl/vft_pkg.sv
package vft_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_FILL    = 2'd1,
      SEQ_RESTORE = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_ON   = 2'd1,
      CMD_OFF  = 2'd2
   } seq_cmd_e;
endpackage

// File: rtl/vft_seq.sv
module vft_seq
   import vft_pkg::*;
#(
   parameter int NUM_WORDS   = 128,
   parameter int BLOCK_WORDS = 8,
   localparam int IDX_W      = $clog2(NUM_WORDS),
   localparam int OFF_W      = $clog2(BLOCK_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_on,
   input  logic             cmd_off,
   output logic             busy,
   output logic             seq_fill,
   output logic [IDX_W-1:0] seq_idx
);
   seq_state_e       st_q;
   seq_cmd_e         pend_q;
   seq_cmd_e         new_cmd;
   seq_cmd_e         eff_cmd;
   logic [IDX_W-1:0] cnt_q;
   logic             promisc_q;

   // enable wins when both commands arrive together (R10)
   always_comb begin
      if (cmd_on)       new_cmd = CMD_ON;
      else if (cmd_off) new_cmd = CMD_OFF;
      else              new_cmd = CMD_NONE;
      eff_cmd = (new_cmd != CMD_NONE) ? new_cmd : pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= SEQ_IDLE;
         pend_q    <= CMD_NONE;
         cnt_q     <= '0;
         promisc_q <= 1'b0;
      end else begin
         case (st_q)
            SEQ_IDLE: begin
               pend_q <= CMD_NONE;
               if (eff_cmd == CMD_ON && !promisc_q) begin
                  st_q      <= SEQ_FILL;
                  cnt_q     <= '1;
                  promisc_q <= 1'b1;
               end else if (eff_cmd == CMD_OFF && promisc_q) begin
                  st_q      <= SEQ_RESTORE;
                  cnt_q     <= '0;
                  promisc_q <= 1'b0;
               end
            end
            SEQ_FILL: begin
               if (new_cmd != CMD_NONE) pend_q <= new_cmd;
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == '0) st_q <= SEQ_IDLE;
            end
            SEQ_RESTORE: begin
               if (new_cmd != CMD_NONE) pend_q <= new_cmd;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == '1) st_q <= SEQ_IDLE;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != SEQ_IDLE);
   assign seq_fill = (st_q == SEQ_FILL);

   // rebuild walks blocks upward and the words inside a block downward
   logic [IDX_W-1:0] rst_idx;
   generate
      if (OFF_W == 0) begin : g_flat
         assign rst_idx = cnt_q;
      end else begin : g_blocked
         assign rst_idx = {cnt_q[IDX_W-1:OFF_W], ~cnt_q[OFF_W-1:0]};
      end
   endgenerate

   assign seq_idx = seq_fill ? cnt_q : rst_idx;

   // length of the current busy run, for the window check
   logic [IDX_W:0] run_len_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    run_len_q <= '0;
      else if (busy) run_len_q <= run_len_q + 1'b1;
      else           run_len_q <= '0;
   end

   assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len_q < (IDX_W+1)'(NUM_WORDS)));

   assert_start_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != SEQ_IDLE) && ($past(st_q) == SEQ_IDLE)) |-> (promisc_q != $past(promisc_q)));
endmodule

// File: rtl/vft_table.sv
module vft_table #(
   parameter int NUM_WORDS = 128,
   parameter int WORD_W    = 32,
   localparam int IDX_W    = $clog2(NUM_WORDS),
   localparam int BIT_W    = $clog2(WORD_W),
   localparam int VID_W    = IDX_W + BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [VID_W-1:0]  lk_vid,
   output logic              lk_hit,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   logic [NUM_WORDS*WORD_W-1:0] flat;

   generate
      for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (we && (wr_idx == IDX_W'(g)))
               word_q <= wr_data;
         end
         assign flat[g*WORD_W +: WORD_W] = word_q;
      end
   endgenerate

   logic [WORD_W-1:0] lk_word;
   assign lk_word = flat[lk_vid[VID_W-1:BIT_W]*WORD_W +: WORD_W];
   assign lk_hit  = lk_word[lk_vid[BIT_W-1:0]];
   assign rd_data = flat[rd_idx*WORD_W +: WORD_W];

   // every accepted write must be visible in the addressed word next cycle
   logic              chk_vld_q;
   logic [IDX_W-1:0]  chk_idx_q;
   logic [WORD_W-1:0] chk_data_q;
   logic [WORD_W-1:0] chk_word;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_vld_q  <= 1'b0;
         chk_idx_q  <= '0;
         chk_data_q <= '0;
      end else begin
         chk_vld_q  <= we;
         chk_idx_q  <= wr_idx;
         chk_data_q <= wr_data;
      end
   end
   assign chk_word = flat[chk_idx_q*WORD_W +: WORD_W];

   assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld_q |-> (chk_word == chk_data_q));
endmodule

// File: rtl/vft_shadow.sv
module vft_shadow #(
   parameter int NUM_WORDS = 128,
   parameter int WORD_W    = 32,
   localparam int IDX_W    = $clog2(NUM_WORDS),
   localparam int BIT_W    = $clog2(WORD_W),
   localparam int VID_W    = IDX_W + BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sh_we,
   input  logic [IDX_W-1:0]  sh_idx,
   input  logic [WORD_W-1:0] sh_data,
   input  logic              mg_we,
   input  logic [VID_W-1:0]  mg_vid,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [WORD_W-1:0] rb_word,
   output logic [VID_W-1:0]  mg_vid_q
);
   logic [NUM_WORDS*WORD_W-1:0] flat;

   generate
      for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (sh_we && (sh_idx == IDX_W'(g)))
               word_q <= sh_data;
         end
         assign flat[g*WORD_W +: WORD_W] = word_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     mg_vid_q <= '0;
      else if (mg_we) mg_vid_q <= mg_vid;
   end

   logic [WORD_W-1:0] mg_mask;
   always_comb begin
      mg_mask = '0;
      if (mg_vid_q[VID_W-1:BIT_W] == rb_idx)
         mg_mask[mg_vid_q[BIT_W-1:0]] = 1'b1;
   end

   assign rb_word = flat[rb_idx*WORD_W +: WORD_W] | mg_mask;
endmodule

// File: rtl/vlan_filter_seq.sv
module vlan_filter_seq #(
   parameter int VID_W       = 12,
   parameter int WORD_W      = 32,
   parameter int BLOCK_WORDS = 8,
   localparam int NUM_WORDS  = (1 << VID_W) / WORD_W,
   localparam int IDX_W      = $clog2(NUM_WORDS),
   localparam int BIT_W      = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              filt_en,
   input  logic [VID_W-1:0]  lk_vid,
   output logic              lk_accept,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [WORD_W-1:0] tbl_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data,
   input  logic              shadow_we,
   input  logic [IDX_W-1:0]  shadow_idx,
   input  logic [WORD_W-1:0] shadow_data,
   input  logic              mgmt_we,
   input  logic [VID_W-1:0]  mgmt_vid,
   input  logic              promisc_on,
   input  logic              promisc_off,
   output logic              busy
);
   generate
      if ((1 << BIT_W) != WORD_W) begin : g_bad_word
         $error("WORD_W must be a power of two");
      end
      if ((1 << $clog2(BLOCK_WORDS)) != BLOCK_WORDS || BLOCK_WORDS > NUM_WORDS) begin : g_bad_block
         $error("BLOCK_WORDS must be a power of two no larger than the table");
      end
      if (VID_W <= BIT_W) begin : g_bad_vid
         $error("VID_W must exceed log2(WORD_W)");
      end
   endgenerate

   logic              seq_fill;
   logic [IDX_W-1:0]  seq_idx;
   logic [WORD_W-1:0] rb_word;
   logic [VID_W-1:0]  mg_vid_q;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [WORD_W-1:0] wr_data;
   logic              lk_hit;

   vft_seq #(.NUM_WORDS(NUM_WORDS), .BLOCK_WORDS(BLOCK_WORDS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_on   (promisc_on),
      .cmd_off  (promisc_off),
      .busy     (busy),
      .seq_fill (seq_fill),
      .seq_idx  (seq_idx)
   );

   vft_shadow #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .sh_we    (shadow_we),
      .sh_idx   (shadow_idx),
      .sh_data  (shadow_data),
      .mg_we    (mgmt_we),
      .mg_vid   (mgmt_vid),
      .rb_idx   (seq_idx),
      .rb_word  (rb_word),
      .mg_vid_q (mg_vid_q)
   );

   // the sequencer owns the write port while it runs; direct writes drop
   always_comb begin
      if (busy) begin
         wr_en   = 1'b1;
         wr_idx  = seq_idx;
         wr_data = seq_fill ? '1 : rb_word;
      end else begin
         wr_en   = tbl_we;
         wr_idx  = tbl_idx;
         wr_data = tbl_data;
      end
   end

   vft_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .lk_vid  (lk_vid),
      .lk_hit  (lk_hit),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   assign lk_accept = !filt_en || lk_hit;

   assert_mgmt_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seq_fill && (seq_idx == mg_vid_q[VID_W-1:BIT_W]))
         |-> wr_data[mg_vid_q[BIT_W-1:0]]);
endmodule

// File: tb/vlan_filter_seq_tb.sv
module vlan_filter_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        filt_en;
   logic [11:0] lk_vid;
   logic        lk_accept;
   logic        tbl_we;
   logic [6:0]  tbl_idx;
   logic [31:0] tbl_data;
   logic [6:0]  rd_idx;
   logic [31:0] rd_data;
   logic        shadow_we;
   logic [6:0]  shadow_idx;
   logic [31:0] shadow_data;
   logic        mgmt_we;
   logic [11:0] mgmt_vid;
   logic        promisc_on;
   logic        promisc_off;
   logic        busy;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   logic [31:0] exp_tbl [128];
   logic [31:0] exp_sh  [128];
   logic [11:0] exp_mg;

   always #10 clk = ~clk;

   vlan_filter_seq u_dut (
      .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .lk_vid(lk_vid),
      .lk_accept(lk_accept), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_data(tbl_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .shadow_we(shadow_we), .shadow_idx(shadow_idx),
      .shadow_data(shadow_data), .mgmt_we(mgmt_we), .mgmt_vid(mgmt_vid),
      .promisc_on(promisc_on), .promisc_off(promisc_off), .busy(busy)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog: run did not finish, got %0d cycles exp <100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [31:0] rebuild_word(int i);
      logic [31:0] w;
      w = exp_sh[i];
      if (int'(exp_mg[11:5]) == i) w[exp_mg[4:0]] = 1'b1;
      return w;
   endfunction

   function automatic logic exp_accept(logic [11:0] v);
      logic [31:0] w;
      w = exp_tbl[v[11:5]];
      return w[v[4:0]];
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic look(string tag, logic [11:0] v);
      lk_vid = v;
      #1;
      check(tag, {31'd0, lk_accept}, {31'd0, filt_en ? exp_accept(v) : 1'b1});
   endtask

   task automatic read_word(string tag, int i, logic [31:0] exp);
      rd_idx = 7'(i);
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic cyc(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic cmd(logic on, logic off);
      @(negedge clk);
      promisc_on  = on;
      promisc_off = off;
      @(negedge clk);
      promisc_on  = 1'b0;
      promisc_off = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 400 && busy; k++) @(negedge clk);
   endtask

   task automatic compare_all(string tag);
      int bad = 0;
      for (int i = 0; i < 128; i++) begin
         rd_idx = 7'(i);
         #1;
         if (rd_data !== exp_tbl[i]) begin
            bad++;
            $display("FAIL %s: word %0d got %h exp %h", tag, i, rd_data, exp_tbl[i]);
         end
      end
      checks++;
      if (bad != 0) failures++;
   endtask

   task automatic tbl_write(int i, logic [31:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 7'(i); tbl_data = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic sh_write(int i, logic [31:0] d);
      @(negedge clk);
      shadow_we = 1'b1; shadow_idx = 7'(i); shadow_data = d;
      @(negedge clk);
      shadow_we = 1'b0;
      exp_sh[i] = d;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; filt_en = 1'b1; lk_vid = '0; tbl_we = 1'b0; tbl_idx = '0;
      tbl_data = '0; rd_idx = '0; shadow_we = 1'b0; shadow_idx = '0;
      shadow_data = '0; mgmt_we = 1'b0; mgmt_vid = '0;
      promisc_on = 1'b0; promisc_off = 1'b0;
      for (int i = 0; i < 128; i++) begin exp_tbl[i] = '0; exp_sh[i] = '0; end
      exp_mg = '0;
      cyc(4);
      rst_n = 1'b1;
      cyc(1);

      // R9 reset state
      check("R9 busy after reset", {31'd0, busy}, 32'd0);
      read_word("R9 word 0 cleared", 0, 32'd0);
      read_word("R9 word 127 cleared", 127, 32'd0);
      look("R9 lookup rejects after reset", 12'h5A5);

      // R2 filter disabled accepts everything
      filt_en = 1'b0;
      look("R2 accept with filter off", 12'h123);
      look("R2 accept with filter off top", 12'hFFF);
      filt_en = 1'b1;

      // R1 table ends
      tbl_write(0, 32'h0000_0001); exp_tbl[0] = 32'h0000_0001;
      tbl_write(127, 32'h8000_0000); exp_tbl[127] = 32'h8000_0000;
      look("R1 vid 0 accepted", 12'h000);
      look("R1 vid 1 rejected", 12'h001);
      look("R1 vid 4095 accepted", 12'hFFF);
      look("R1 vid 4094 rejected", 12'hFFE);

      // R1/R7 random mix of direct writes, shadow writes and lookups
      for (int it = 0; it < 150; it++) begin
         int i = int'($urandom_range(0, 127));
         logic [31:0] d = $urandom();
         if ($urandom_range(0, 2) == 0) sh_write(i, d);
         else begin
            tbl_write(i, d);
            exp_tbl[i] = d;
            read_word("R7 direct write readback", i, d);
         end
         look("R1 random lookup", {7'(i), 5'($urandom_range(0, 31))});
         look("R1 random lookup any", 12'($urandom()));
      end

      // R4 disable while not promiscuous does nothing
      tbl_write(9, 32'h0BAD_F00D); exp_tbl[9] = 32'h0BAD_F00D;
      cmd(1'b0, 1'b1);
      check("R4 off when not promiscuous keeps idle", {31'd0, busy}, 32'd0);
      cyc(2);
      read_word("R4 off when not promiscuous keeps word", 9, 32'h0BAD_F00D);

      // R3 fill
      cmd(1'b1, 1'b0);
      check("R3 busy right after command", {31'd0, busy}, 32'd1);
      cyc(1);
      read_word("R3 first fill write is word 127", 127, 32'hFFFF_FFFF);
      read_word("R3 word 126 not yet filled", 126, exp_tbl[126]);
      cyc(126);
      check("R3 busy at fill cycle 127", {31'd0, busy}, 32'd1);
      read_word("R3 word 0 filled last", 0, exp_tbl[0]);
      cyc(1);
      check("R3 busy low after 128 writes", {31'd0, busy}, 32'd0);
      for (int i = 0; i < 128; i++) exp_tbl[i] = 32'hFFFF_FFFF;
      compare_all("R3 table all ones");

      // R4 enable while promiscuous does nothing
      tbl_write(5, 32'h0000_1234); exp_tbl[5] = 32'h0000_1234;
      cmd(1'b1, 1'b0);
      check("R4 on when promiscuous keeps idle", {31'd0, busy}, 32'd0);
      cyc(2);
      read_word("R4 on when promiscuous keeps word", 5, 32'h0000_1234);

      // R5/R6 rebuild with management VID 0
      sh_write(0, 32'h0000_00F0);
      sh_write(8, 32'h1357_9BDE);
      sh_write(15, 32'hCAFE_0015);
      cmd(1'b0, 1'b1);
      cyc(9);
      read_word("R5 block 1 starts at word 15", 15, rebuild_word(15));
      read_word("R5 word 8 not yet rebuilt", 8, 32'hFFFF_FFFF);
      read_word("R6 mgmt vid 0 kept in word 0", 0, 32'h0000_00F1);
      // R7 direct write during busy ignored
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 7'd0; tbl_data = 32'hDEAD_BEEF;
      @(negedge clk);
      tbl_we = 1'b0;
      read_word("R7 write while busy ignored", 0, 32'h0000_00F1);
      wait_idle();
      for (int i = 0; i < 128; i++) exp_tbl[i] = rebuild_word(i);
      compare_all("R5 table rebuilt from shadow");

      // R6 moved management VID
      @(negedge clk);
      mgmt_we = 1'b1; mgmt_vid = 12'h9A3;
      @(negedge clk);
      mgmt_we = 1'b0; exp_mg = 12'h9A3;
      sh_write(77, 32'h0000_0000);
      cmd(1'b1, 1'b0);
      wait_idle();
      cmd(1'b0, 1'b1);
      wait_idle();
      for (int i = 0; i < 128; i++) exp_tbl[i] = rebuild_word(i);
      read_word("R6 mgmt bit forced in word 77", 77, 32'h0000_0008);
      read_word("R6 word 0 from shadow only", 0, 32'h0000_00F0);
      look("R6 mgmt vid accepted", 12'h9A3);
      look("R6 neighbour vid rejected", 12'h9A4);

      // R8 command held while busy
      cmd(1'b1, 1'b0);
      cyc(5);
      cmd(1'b0, 1'b1);
      wait_idle();
      @(negedge clk);
      check("R8 held disable starts after fill", {31'd0, busy}, 32'd1);
      wait_idle();
      compare_all("R8 table rebuilt after held command");

      // R10 simultaneous commands: enable wins
      cmd(1'b1, 1'b1);
      check("R10 simultaneous commands start sequence", {31'd0, busy}, 32'd1);
      cyc(1);
      read_word("R10 enable taken fills word 127", 127, 32'hFFFF_FFFF);
      wait_idle();
      for (int i = 0; i < 128; i++) exp_tbl[i] = 32'hFFFF_FFFF;
      compare_all("R10 table all ones");
      look("R3 any vid accepted when promiscuous", 12'h777);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule